// File: doc/BRIEF.md
# Power-Management Wake Status and Interrupt Logic

This block keeps sticky status flags for the power-management event sources of a system: a parameterised group of general wake inputs, a sleep button, a real-time-clock alarm, a power button and the overflow of a power-management timer. The flags sit in one status word. Another block reads that word, and software clears any flag by writing a one to its bit. The block also keeps one global wake flag. It sends a single-cycle wake request toward the sleep and standby sequencers. It drives a level interrupt that stays high while any flag that is also enabled is set.

The sources do not all behave the same. A general wake input is recorded only when its enable is set. The three buttons and the alarm are always recorded, but they wake the system and raise the interrupt only when enabled. The timer overflow is always recorded and can raise the interrupt when enabled, but it never wakes the system. The event pulses are expected to be debounced and synchronous to the clock. The address decoding for the clear write is done outside this block.

Status word layout (N = `GEN_W`): bits N-1..0 are the general inputs, bit N is the sleep button, bit N+1 is the alarm, bit N+2 is the power button, bit N+3 is the timer overflow, and bit N+4 is the global wake flag. The enable vector uses the same layout for bits N+3..0.

Top module: `pm_wake_sci`

## Requirements
- R1: During and after reset, every status bit, `wake_req_o` and `sci_o` are 0.
- R2: A general input pulse with its enable set makes its status bit, the global wake flag (bit N+4) and `sci_o` read 1 after the next clock edge. With its enable clear, the pulse leaves its status bit at 0.
- R3: A pulse on the sleep button, alarm or power button sets its status bit (N, N+1, N+2) after the next edge, whatever the value of its enable.
- R4: Those three sources set the global wake flag and drive `sci_o` only when their enable bit is 1.
- R5: A timer overflow pulse always sets status bit N+3. It never sets the global wake flag and never produces `wake_req_o`.
- R6: A latched timer overflow drives `sci_o` only while enable bit N+3 is 1.
- R7: A write with `wr_en_i` high clears, at the next edge, every status bit (including the wake flag) whose `wr_data_i` bit is 1. Bits written with 0 keep their value.
- R8: If a bit is set by an event and cleared by a write in the same cycle, the bit reads 1 afterwards.
- R9: `sci_o` is the OR over bits N+3..0 of status AND enable. It stays high until the causing bits are cleared or disabled.
- R10: `wake_req_o` is high for exactly one cycle, in the cycle the global wake flag first reads 1. It stays low while the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gen_evt_i | input | GEN_W | General wake event pulses |
| slpbtn_evt_i | input | 1 | Sleep button pulse |
| rtc_evt_i | input | 1 | Alarm pulse |
| pwrbtn_evt_i | input | 1 | Power button pulse |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| src_en_i | input | GEN_W+4 | Per-source enables, laid out like status bits N+3..0 |
| wr_en_i | input | 1 | Clear-write strobe |
| wr_data_i | input | GEN_W+5 | Write-one-to-clear mask |
| stat_o | output | GEN_W+5 | Status word |
| wake_req_o | output | 1 | One-cycle wake request |
| sci_o | output | 1 | Level interrupt |

## Verification
Two functions can act on the same bit in one cycle: an event on a source and a clear write aimed at that bit's status. The bench provokes this on the alarm bit and on the global wake flag. In the same cycle it pulses the event and writes ones to those bits. It then requires both bits to read 1 and the interrupt to stay high. A second case pairs an event on one bit with a clear of a different bit. There the bench expects the cleared bit to fall and the new bit to rise in the same edge.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  localparam int unsigned FIX_SLP  = 0;
  localparam int unsigned FIX_RTC  = 1;
  localparam int unsigned FIX_PWR  = 2;
  localparam int unsigned FIX_TMR  = 3;
  localparam int unsigned FIX_N    = 4;
  localparam int unsigned FIX_WAKE = 3;

  typedef struct packed {
    logic tmr;
    logic pwr;
    logic rtc;
    logic slp;
  } fix_evt_t;
endpackage

// File: rtl/pm_stat_cell.sv
module pm_stat_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic upd;

  always_comb begin
    upd = set_i | clr_i;
    q_d = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= 1'b0;
    end else if (upd) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/pm_wake_agg.sv
module pm_wake_agg #(
  parameter int unsigned WAKE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAKE_W-1:0] wake_set_i,
  input  logic              clr_i,
  output logic              wake_o,
  output logic              req_o
);
  logic any_set;
  logic wake_q, wake_d;
  logic req_q, req_d;
  logic upd;

  always_comb begin
    any_set = |wake_set_i;
    upd     = any_set | clr_i;
    wake_d  = any_set;
    req_d   = (any_set | (wake_q & ~clr_i)) & ~wake_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= 1'b0;
    end else if (upd) begin
      wake_q <= wake_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign wake_o = wake_q;
  assign req_o  = req_q;

  p_req_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  p_req_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> wake_o);
  p_no_spurious_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_o && !any_set) |=> !wake_o);
endmodule

// File: rtl/pm_irq_merge.sv
module pm_irq_merge #(
  parameter int unsigned SRC_W = 12
) (
  input  logic [SRC_W-1:0] stat_i,
  input  logic [SRC_W-1:0] en_i,
  output logic             irq_o
);
  logic [SRC_W-1:0] hit;

  always_comb begin
    hit   = stat_i & en_i;
    irq_o = |hit;
  end
endmodule

// File: rtl/pm_wake_sci.sv
module pm_wake_sci
  import pm_wake_pkg::*;
#(
  parameter int unsigned GEN_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [GEN_W-1:0]         gen_evt_i,
  input  logic                     slpbtn_evt_i,
  input  logic                     rtc_evt_i,
  input  logic                     pwrbtn_evt_i,
  input  logic                     tmr_ovf_i,
  input  logic [GEN_W+FIX_N-1:0]   src_en_i,
  input  logic                     wr_en_i,
  input  logic [GEN_W+FIX_N:0]     wr_data_i,
  output logic [GEN_W+FIX_N:0]     stat_o,
  output logic                     wake_req_o,
  output logic                     sci_o
);
  localparam int unsigned SRC_W  = GEN_W + FIX_N;
  localparam int unsigned REG_W  = SRC_W + 1;
  localparam int unsigned WAKE_W = GEN_W + FIX_WAKE;
  localparam int unsigned IDX_W  = SRC_W;

  fix_evt_t         fix_evt;
  logic [SRC_W-1:0] evt_all;
  logic [SRC_W-1:0] set_v;
  logic [SRC_W-1:0] clr_v;
  logic [SRC_W-1:0] src_stat;
  logic [WAKE_W-1:0] wake_set;
  logic             wake_clr;
  logic             wake_flag;

  always_comb begin
    fix_evt.slp = slpbtn_evt_i;
    fix_evt.rtc = rtc_evt_i;
    fix_evt.pwr = pwrbtn_evt_i;
    fix_evt.tmr = tmr_ovf_i;
    evt_all     = {fix_evt, gen_evt_i};
    clr_v       = wr_en_i ? wr_data_i[SRC_W-1:0] : '0;
    wake_clr    = wr_en_i & wr_data_i[IDX_W];
    wake_set    = evt_all[WAKE_W-1:0] & src_en_i[WAKE_W-1:0];
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    if (i < GEN_W) begin : g_gated
      assign set_v[i] = evt_all[i] & src_en_i[i];
    end else begin : g_always
      assign set_v[i] = evt_all[i];
    end

    pm_stat_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .q_o    (src_stat[i])
    );
  end

  pm_wake_agg #(.WAKE_W(WAKE_W)) u_agg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wake_set_i (wake_set),
    .clr_i      (wake_clr),
    .wake_o     (wake_flag),
    .req_o      (wake_req_o)
  );

  pm_irq_merge #(.SRC_W(SRC_W)) u_irq (
    .stat_i (src_stat),
    .en_i   (src_en_i),
    .irq_o  (sci_o)
  );

  assign stat_o = {wake_flag, src_stat};

  p_btn_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slpbtn_evt_i || rtc_evt_i || pwrbtn_evt_i) |=> |stat_o[GEN_W+FIX_PWR:GEN_W+FIX_SLP]);
  p_tmr_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> stat_o[GEN_W+FIX_TMR]);
  p_gen_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_evt_i[0] && !src_en_i[0] && !stat_o[0]) |=> !stat_o[0]);
  p_sci_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sci_o && !wr_en_i) ##1 $stable(src_en_i) |-> sci_o);
  p_rst_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (rst_ni || (stat_o == '0 && !wake_req_o)));
endmodule

// File: tb/test_pm_wake_sci.sv
`timescale 1ns/1ps
module test_pm_wake_sci;
  localparam int GEN_W = 8;
  localparam int SRC_W = GEN_W + 4;
  localparam int REG_W = SRC_W + 1;
  localparam int B_SLP = GEN_W, B_RTC = GEN_W+1, B_PWR = GEN_W+2, B_TMR = GEN_W+3, B_WAK = GEN_W+4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [GEN_W-1:0] gen_evt = '0;
  logic slp = 1'b0, rtc = 1'b0, pwr = 1'b0, tmr = 1'b0;
  logic [SRC_W-1:0] en = '0;
  logic wr = 1'b0;
  logic [REG_W-1:0] wd = '0;
  logic [REG_W-1:0] stat;
  logic wreq, sci;

  always #2.5 clk = ~clk;

  pm_wake_sci #(.GEN_W(GEN_W)) i_pm_wake_sci (
    .clk_i(clk), .rst_ni(rst_n), .gen_evt_i(gen_evt), .slpbtn_evt_i(slp),
    .rtc_evt_i(rtc), .pwrbtn_evt_i(pwr), .tmr_ovf_i(tmr), .src_en_i(en),
    .wr_en_i(wr), .wr_data_i(wd), .stat_o(stat), .wake_req_o(wreq), .sci_o(sci));

  int n_chk = 0, n_fail = 0;
  bit reported = 0;

  logic [REG_W-1:0] q_stat[$];
  logic q_req[$];
  logic q_sci[$];
  string q_tag[$];

  logic [GEN_W-1:0] p_gen = '0;
  logic p_slp = 0, p_rtc = 0, p_pwr = 0, p_tmr = 0, p_wr = 0;
  logic [REG_W-1:0] p_wd = '0;
  logic [SRC_W-1:0] p_en = '0;
  logic [SRC_W-1:0] m_stat = '0;
  logic m_wake = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic tick(input string tag);
    logic [SRC_W-1:0] ev, setv, clrv, nstat;
    logic wset, nwake;
    @(negedge clk);
    gen_evt = p_gen; slp = p_slp; rtc = p_rtc; pwr = p_pwr; tmr = p_tmr;
    en = p_en; wr = p_wr; wd = p_wd;
    ev    = {p_tmr, p_pwr, p_rtc, p_slp, p_gen};
    setv  = ev & {4'b1111, p_en[GEN_W-1:0]};
    wset  = |(ev[SRC_W-2:0] & p_en[SRC_W-2:0]);
    clrv  = p_wr ? p_wd[SRC_W-1:0] : '0;
    nstat = setv | (m_stat & ~clrv);
    nwake = wset | (m_wake & ~(p_wr & p_wd[B_WAK]));
    q_stat.push_back({nwake, nstat});
    q_req.push_back(nwake & ~m_wake);
    q_sci.push_back(|(nstat & p_en));
    q_tag.push_back(tag);
    m_stat = nstat; m_wake = nwake;
    p_gen = '0; p_slp = 0; p_rtc = 0; p_pwr = 0; p_tmr = 0; p_wr = 0; p_wd = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_tag.size() > 0) begin
        logic [REG_W-1:0] es;
        logic er, ei;
        string t;
        es = q_stat.pop_front(); er = q_req.pop_front();
        ei = q_sci.pop_front(); t = q_tag.pop_front();
        chk(stat === es, t, "stat", 32'(stat), 32'(es));
        chk(wreq === er, t, "wake_req", 32'(wreq), 32'(er));
        chk(sci === ei, t, "sci", 32'(sci), 32'(ei));
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(stat === '0 && wreq === 1'b0, "R1", "reset outputs", 32'(stat), 0);
    rst_n = 1'b1;
    tick("R1 idle after reset");

    p_en[2] = 1; p_gen[2] = 1; tick("R2 enabled general sets wake, R10 pulse");
    tick("R10 no repeat pulse");
    p_en[5] = 1; p_gen[5] = 1; tick("R10 second event while flag set");
    p_gen[3] = 1; tick("R2 disabled general ignored");
    p_wr = 1; p_wd = '1; tick("R7 clear all");
    p_en = '0;

    p_slp = 1; tick("R3 R4 sleep button disabled");
    p_pwr = 1; tick("R3 R4 power button disabled");
    p_en[B_RTC] = 1; p_rtc = 1; tick("R4 alarm enabled wakes");
    p_wr = 1; p_wd = '0; tick("R7 zero write keeps bits");
    p_wr = 1; p_wd[B_SLP] = 1; tick("R7 clear sleep bit only");

    p_rtc = 1; p_wr = 1; p_wd[B_RTC] = 1; p_wd[B_WAK] = 1;
    tick("R8 set wins over clear");
    p_gen[1] = 1; p_en[1] = 1; p_wr = 1; p_wd[B_PWR] = 1;
    tick("R8 R7 set one clear another");
    p_wr = 1; p_wd = '1; tick("R7 clear everything");
    p_en = '0;

    p_tmr = 1; tick("R5 R6 timer disabled");
    p_en[B_TMR] = 1; tick("R6 timer enable raises sci, R5 no wake");
    p_en[B_TMR] = 0; tick("R6 R9 disabling drops sci");
    p_en[B_TMR] = 1; p_en[0] = 1; p_gen[0] = 1; tick("R9 two causes");
    p_wr = 1; p_wd[B_TMR] = 1; tick("R9 one cause left");
    tick("R9 holds");
    p_wr = 1; p_wd[0] = 1; tick("R9 last cause cleared");
    p_wr = 1; p_wd[B_WAK] = 1; tick("R7 wake flag cleared");
    p_en[B_PWR] = 1; p_pwr = 1; tick("R4 R10 power button re-wakes");
    tick("R10 idle");

    @(posedge clk); #2;
    report();
  end
endmodule